// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block is the control register of an I2C master that owns the start, repeated start and stop conditions on the bus. It watches SDA and SCL through synchronizers and keeps a bus-busy flag. The flag follows the conditions seen on the wires, whichever master caused them. Software cannot write the flag. Instead, software writes one byte whose top two bits form a command. Bit 7 set with bit 6 clear requests a start, and the block turns it into a repeated start when the bus is already busy. Bit 7 clear with bit 6 clear requests a stop. Any byte with bit 6 set carries no command.

Each write also sets the SDA output-value bit, which can hold the SDA line low by itself. The sequencer times its SDA/SCL steps from two count inputs, a hold count and a setup count. It marks the end of every sequence with a one-cycle done pulse. Both pins are open-drain: an output of 1 pulls the line low, and an output of 0 releases it to the pull-up.

Top module: `i2c_cond_ctl`

## Requirements
- R1: After reset, rd_data reads 0x60 and both drive-low outputs are 0.
- R2: rd_data bit 6 always reads 1 and rd_data bits 4:0 always read 0.
- R3: Every write copies wr_data bit 5 into the SDA value bit. A value of 0 pulls SDA low and 1 releases it. rd_data bit 5 always equals the inverse of sda_drive_low.
- R4: The busy flag (rd_data bit 7) is set when synchronized SDA goes from 1 to 0 while synchronized SCL is 1 in both the previous and the current sample. This holds whether the block or another device moves the line.
- R5: The busy flag is cleared when synchronized SDA goes from 0 to 1 while synchronized SCL is 1 in both samples.
- R6: An SDA change while SCL is low, or in the same sample in which SCL rises, leaves the busy flag unchanged.
- R7: A write with bit 7 = 1 and bit 6 = 0 while not busy runs a start. SDA is pulled low with SCL released for max(hold_cycles,1) cycles, then SCL is pulled low. seq_done is first seen in sample hold+1 after the write edge.
- R8: The same write while busy runs a repeated start. SDA is released while SCL is held low for 1 cycle, then SCL is released for max(setup_cycles,1) cycles, then the start of R7 runs. seq_done appears in sample setup+hold+2.
- R9: A write with bit 7 = 0 and bit 6 = 0 runs a stop. Both lines are held low for 1 cycle, then SCL is released for max(setup_cycles,1) cycles, then SDA is released. seq_done appears in sample setup+2.
- R10: A write with bit 6 = 1 starts no sequence and does not change the busy flag. It still updates the SDA value bit.
- R11: A command written while a sequence is running is ignored, and the running sequence keeps its timing.
- R12: seq_done is high for exactly one cycle per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write byte |
| rd_data | output | 8 | Register read byte |
| hold_cycles | input | CNT_W | Start hold count (SDA low to SCL low) |
| setup_cycles | input | CNT_W | Setup count before a stop or repeated start edge |
| sda_pin | input | 1 | Sampled SDA line level |
| scl_pin | input | 1 | Sampled SCL line level |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Random bytes with bit 6 set toggle the SDA value bit while SCL idles high. Each toggle is a genuine start or stop on the wire, so the busy flag must follow the inverse of the last written bit 5, and no done pulse may appear. An external device model then drives starts and stops. It also moves SDA while SCL is low, and releases SDA and SCL in the same cycle; these cases separate a true condition from a data-phase edge or a skewed release. Start, repeated start and stop commands are then run with random and zero counts. The measured length of each sequence tells a start from a repeated start and shows whether zero counts are clamped. A command written in the middle of a start shows whether it is ignored.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  localparam int BUSY_BIT = 7;
  localparam int GATE_BIT = 6;
  localparam int SDAV_BIT = 5;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_START,
    CMD_STOP
  } cmd_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START_HOLD,
    SQ_STOP_LOW,
    SQ_STOP_SETUP,
    SQ_RS_SDA,
    SQ_RS_SETUP
  } seq_state_t;

  // A set gate bit suppresses any command.
  function automatic cmd_t decode_cmd(input logic [7:0] d);
    if (d[GATE_BIT]) return CMD_NONE;
    if (d[BUSY_BIT]) return CMD_START;
    return CMD_STOP;
  endfunction

  function automatic logic [7:0] pack_status(input logic busy, input logic sda_level);
    logic [7:0] r;
    r = 8'h00;
    r[BUSY_BIT] = busy;
    r[GATE_BIT] = 1'b1;
    r[SDAV_BIT] = sda_level;
    return r;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Lines idle high, so the stages reset to 1 to avoid a false condition.
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '1;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic start_seen,
  output logic stop_seen
);
  logic sda_p, scl_p, scl_steady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_p <= 1'b1;
      scl_p <= 1'b1;
    end else begin
      sda_p <= sda_s;
      scl_p <= scl_s;
    end
  end

  assign scl_steady = scl_p & scl_s;
  assign start_seen = scl_steady & sda_p & ~sda_s;
  assign stop_seen  = scl_steady & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  cmd_t             cmd,
  input  logic             bus_busy,
  input  logic [CNT_W-1:0] hold_cycles,
  input  logic [CNT_W-1:0] setup_cycles,
  output logic             sda_low,
  output logic             scl_low,
  output logic             done,
  output logic             idle
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  // A zero count is clamped to one cycle.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] n);
    return (n == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : n;
  endfunction

  function automatic logic last_cycle(input logic [CNT_W-1:0] c);
    return c <= {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign idle = (state == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      sda_low <= 1'b0;
      scl_low <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (cmd_valid && cmd == CMD_START) begin
            if (bus_busy) begin
              state   <= SQ_RS_SDA;
              sda_low <= 1'b0;
              scl_low <= 1'b1;
            end else begin
              state   <= SQ_START_HOLD;
              sda_low <= 1'b1;
              scl_low <= 1'b0;
              cnt     <= eff_count(hold_cycles);
            end
          end else if (cmd_valid && cmd == CMD_STOP) begin
            state   <= SQ_STOP_LOW;
            sda_low <= 1'b1;
            scl_low <= 1'b1;
          end
        end
        SQ_START_HOLD: begin
          if (last_cycle(cnt)) begin
            scl_low <= 1'b1;
            done    <= 1'b1;
            state   <= SQ_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        SQ_STOP_LOW: begin
          scl_low <= 1'b0;
          cnt     <= eff_count(setup_cycles);
          state   <= SQ_STOP_SETUP;
        end
        SQ_STOP_SETUP: begin
          if (last_cycle(cnt)) begin
            sda_low <= 1'b0;
            done    <= 1'b1;
            state   <= SQ_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        SQ_RS_SDA: begin
          scl_low <= 1'b0;
          cnt     <= eff_count(setup_cycles);
          state   <= SQ_RS_SETUP;
        end
        SQ_RS_SETUP: begin
          if (last_cycle(cnt)) begin
            sda_low <= 1'b1;
            cnt     <= eff_count(hold_cycles);
            state   <= SQ_START_HOLD;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cond_ctl.sv
module i2c_cond_ctl
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [CNT_W-1:0] hold_cycles,
  input  logic [CNT_W-1:0] setup_cycles,
  input  logic             sda_pin,
  input  logic             scl_pin,
  output logic             sda_drive_low,
  output logic             scl_drive_low,
  output logic             seq_done
);
  logic [1:0] lines_s;
  logic       start_seen, stop_seen;
  logic       busy_q, sdav_q;
  logic       seq_sda_low, seq_scl_low, seq_idle;
  cmd_t       cmd;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_pin, scl_pin}), .q(lines_s)
  );

  i2c_cond_detect u_det (
    .clk(clk), .rst_n(rst_n), .sda_s(lines_s[1]), .scl_s(lines_s[0]),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  assign cmd = decode_cmd(wr_data);

  i2c_cond_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(wr_en), .cmd(cmd), .bus_busy(busy_q),
    .hold_cycles(hold_cycles), .setup_cycles(setup_cycles),
    .sda_low(seq_sda_low), .scl_low(seq_scl_low), .done(seq_done), .idle(seq_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sdav_q <= 1'b1;
    end else begin
      if (start_seen)     busy_q <= 1'b1;
      else if (stop_seen) busy_q <= 1'b0;
      if (wr_en) sdav_q <= wr_data[SDAV_BIT];
    end
  end

  assign sda_drive_low = ~sdav_q | seq_sda_low;
  assign scl_drive_low = seq_scl_low;
  assign rd_data       = pack_status(busy_q, ~sda_drive_low);
endmodule

// File: rtl/i2c_cond_ctl_chk.sv
module i2c_cond_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sda_drive_low,
  input logic       seq_done,
  input logic       busy_q,
  input logic       start_seen,
  input logic       stop_seen,
  input logic       seq_idle
);
  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] && rd_data[4:0] == 5'd0);

  p_sda_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] == !sda_drive_low);

  p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> rd_data[7]);

  p_busy_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !rd_data[7]);

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_seen && !stop_seen) |=> $stable(busy_q));

  p_no_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6] && seq_idle) |=> (seq_idle && !seq_done));

  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !seq_idle) |=> !seq_idle || seq_done);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);
endmodule

bind i2c_cond_ctl i2c_cond_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .sda_drive_low(sda_drive_low), .seq_done(seq_done), .busy_q(busy_q),
  .start_seen(start_seen), .stop_seen(stop_seen), .seq_idle(seq_idle)
);

// File: tb/i2c_cond_ctl_bench.sv
`timescale 1ns/1ps
module i2c_cond_ctl_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = 8'h00;
  logic [7:0]       rd_data;
  logic [CNT_W-1:0] hold_cycles = '0;
  logic [CNT_W-1:0] setup_cycles = '0;
  logic             sda_drive_low, scl_drive_low, seq_done;
  logic             ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic             sda_pin, scl_pin;
  int               n_vec = 0, n_bad = 0, done_cnt = 0;
  bit               finished = 0;

  always #4 clk = ~clk;

  // Open-drain wired-AND bus with an external device model.
  assign sda_pin = !(sda_drive_low || ext_sda_low);
  assign scl_pin = !(scl_drive_low || ext_scl_low);

  i2c_cond_ctl #(.CNT_W(CNT_W)) u_i2c_cond_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hold_cycles(hold_cycles), .setup_cycles(setup_cycles),
    .sda_pin(sda_pin), .scl_pin(scl_pin),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low), .seq_done(seq_done)
  );

  always @(posedge clk) if (seq_done) done_cnt++;

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // kind: 0 start, 1 repeated start, 2 stop
  function automatic int seq_len(input int kind, input int h, input int s);
    if (kind == 0) return eff(h) + 1;
    if (kind == 1) return eff(s) + eff(h) + 2;
    return eff(s) + 2;
  endfunction

  function automatic logic [7:0] exp_rd(input logic busy, input logic sda_lvl);
    return {busy, 1'b1, sda_lvl, 5'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Returns the sample index (1 = first negedge after the write edge) of done.
  task automatic wait_done(input int first, output int k);
    k = first;
    while (!seq_done && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_seq(input logic [7:0] d, input int kind, input string req);
    int h, s, k;
    h = hold_cycles;
    s = setup_cycles;
    do_write(d);
    wait_done(1, k);
    chk(req, k, seq_len(kind, h, s));
    @(negedge clk);
    chk("R12", seq_done, 0);
  endtask

  initial begin
    int seed;
    logic [7:0] d;
    int k, dc;
    seed = $urandom(32'h5eed);
    settle(3);
    chk("R1", rd_data, 8'h60);
    chk("R1", {sda_drive_low, scl_drive_low}, 2'b00);
    rst_n = 1'b1;
    settle(2);

    // Random register-only writes: SDA toggles with SCL high.
    for (int i = 0; i < 40; i++) begin
      d = 8'($urandom);
      d[6] = 1'b1;
      dc = done_cnt;
      do_write(d);
      settle(6);
      chk("R10", done_cnt, dc);
      chk("R3", sda_drive_low, !d[5]);
      chk("R2", rd_data & 8'h5f, 8'h40);
      chk("R4", rd_data, exp_rd(!d[5], d[5]));
    end
    do_write(8'h60);
    settle(6);
    chk("R5", rd_data, 8'h60);

    // External device conditions.
    ext_sda_low = 1'b1; settle(6);
    chk("R4", rd_data[7], 1);
    ext_scl_low = 1'b1; settle(4);
    ext_sda_low = 1'b0; settle(6);
    chk("R6", rd_data[7], 1);
    ext_sda_low = 1'b1; settle(4);
    ext_sda_low = 1'b0; ext_scl_low = 1'b0; settle(6);
    chk("R6", rd_data[7], 1);
    ext_sda_low = 1'b1; settle(4);
    ext_sda_low = 1'b0; settle(6);
    chk("R5", rd_data[7], 0);

    // Command sequences, first with zero counts, then random counts.
    for (int i = 0; i < 8; i++) begin
      hold_cycles  = (i == 0) ? 0 : CNT_W'($urandom_range(0, 9));
      setup_cycles = (i == 0) ? 0 : CNT_W'($urandom_range(0, 9));
      run_seq(8'hA0, 0, "R7");
      chk("R7", {sda_drive_low, scl_drive_low}, 2'b11);
      settle(5);
      chk("R7", rd_data, exp_rd(1, 0));
      dc = done_cnt;
      do_write(8'hE0);
      settle(10);
      chk("R10", done_cnt, dc);
      chk("R10", {rd_data, sda_drive_low, scl_drive_low}, {exp_rd(1, 0), 2'b11});
      hold_cycles  = CNT_W'($urandom_range(0, 9));
      setup_cycles = CNT_W'($urandom_range(0, 9));
      run_seq(8'hA0, 1, "R8");
      settle(5);
      chk("R8", {rd_data, sda_drive_low, scl_drive_low}, {exp_rd(1, 0), 2'b11});
      run_seq(8'h20, 2, "R9");
      settle(5);
      chk("R9", {rd_data, sda_drive_low, scl_drive_low}, {8'h60, 2'b00});
    end

    // Stop command written in the middle of a start is ignored.
    hold_cycles = 8;
    do_write(8'hA0);
    do_write(8'h20);
    wait_done(3, k);
    chk("R11", k, seq_len(0, 8, 0));
    settle(5);
    chk("R11", {rd_data, sda_drive_low, scl_drive_low}, {exp_rd(1, 0), 2'b11});
    setup_cycles = 2;
    run_seq(8'h20, 2, "R9");
    settle(5);
    chk("R9", rd_data, 8'h60);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule